// File: doc/BRIEF.md
# Flash Read Front End with Clocked Burst Mode

This block is the read side of a NOR-style flash model. After reset it answers plain asynchronous reads: while the chip is selected and the output enable is low, the data bus shows the word at the address inputs with no clock involved. When the host writes the read configuration register, at any address, the block switches to clocked burst reads. In that mode the host marks a start address once. An internal address generator then steps on each clock, and a wait flag covers the first-access latency.

The configuration word selects a burst length (a wrap of 4, a wrap of 8, or a linear run) and a first-access latency. The block also keeps two low-power flags. One shows standby while the chip is deselected. The other shows automatic power saving while the chip is selected but idle. The array is a small register file with fixed contents, so reads are deterministic. The reset input is synchronous and active high.

Top module: `flash_burst_rd`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to async mode with burst length code 0 and latency 0. After that edge, `dq_wait`, `standby` and `psave` are 0.
- R2: The array word at address a is {a[7:0] XOR 8'h5A, ~a[7:0]}. In async mode, with `sel_n`=0 and `rd_en_n`=0, `dq` shows the word at `addr` combinationally.
- R3: `dq_en` is 1 only when `sel_n`=0 and `rd_en_n`=0. Whenever `dq_en` is 0, `dq` is 0.
- R4: At a clock edge where `sel_n`=0 and `wr_n`=0, the block stores the configuration from `din`, whatever `addr` holds. `din[1:0]` is the length code and `din[4:2]` is the latency L. The block enters burst mode and abandons any burst in progress. In burst mode, with no burst running, `dq` is 0 and `dq_wait` is 0.
- R5: In burst mode, an edge with `sel_n`=0, `addr_vld_n`=0 and `wr_n`=1 loads the start address. `dq_wait` is then 1 for the L cycles after that edge and `dq` is 0 during them. The first word appears L edges after the load edge. `addr` is ignored after the load edge.
- R6: Once the latency has run out, each clock edge advances the burst address by one word, giving one new word per cycle.
- R7: Length code 0 wraps within an aligned group of 4 words. Length code 1 wraps within an aligned group of 8 words.
- R8: Length codes 2 and 3 run linearly and wrap at the end of the array.
- R9: An edge with `sel_n`=1 sets `standby` and clears `psave`. It also ends the running burst, so `dq_wait` goes to 0. When the chip is selected again, no data appears until a new start address is loaded.
- R10: An edge with `sel_n`=0, `rd_en_n`=1, `wr_n`=1 and `addr_vld_n`=1 sets `psave`. An edge with `sel_n`=0 where any of those three inputs is active clears `psave` and `standby`.
- R11: A reset in the middle of a burst ends the burst and returns the block to async reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high device reset |
| sel_n | input | 1 | Chip select, active low |
| rd_en_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write strobe for the configuration register, active low |
| addr_vld_n | input | 1 | Start-address strobe, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Configuration data |
| dq | output | DATA_W | Read data, 0 while the driver is off |
| dq_en | output | 1 | Data driver enable for the pad |
| dq_wait | output | 1 | High while burst data is not yet valid |
| standby | output | 1 | Deselected low-power state |
| psave | output | 1 | Selected but idle, automatic power saving |

## Verification
The assertions check on every cycle that a deselect leads to standby and drops the wait flag. They also check that a configuration write enters burst mode, that reset returns the block to async mode, that an active read clears power saving, and that the wait flag never shows outside burst mode. The address sequence cannot be shown by a property: the order of words, the wraps for each length, and where the first word lands for each latency. The bench scenarios show these by comparing every burst word against a computed address pattern. The same holds for async data, the ignored configuration address and recovery from a reset in the middle of a burst.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    localparam int LAT_W = 3;

    typedef enum logic [1:0] {
        BL_FOUR  = 2'd0,
        BL_EIGHT = 2'd1,
        BL_LIN   = 2'd2,
        BL_LIN2  = 2'd3
    } blen_e;

    typedef struct packed {
        logic             burst;
        blen_e            blen;
        logic [LAT_W-1:0] lat;
    } rd_cfg_t;

    localparam rd_cfg_t CFG_RESET = '{burst: 1'b0, blen: BL_FOUR, lat: '0};

    function automatic logic [15:0] pattern_word(input logic [7:0] a);
        return {a ^ 8'h5A, ~a};
    endfunction

endpackage

// File: rtl/flash_rd_array.sv
module flash_rd_array
    import flash_rd_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] raddr_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign mem[i] = DATA_W'(pattern_word(8'(i)));
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/flash_rd_cfg.sv
module flash_rd_cfg
    import flash_rd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] din,
    output rd_cfg_t           cfg
);
    logic cfg_unused;
    assign cfg_unused = ^din[DATA_W-1:2+LAT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (wr_stb) begin
            cfg.burst <= 1'b1;
            cfg.blen  <= blen_e'(din[1:0]);
            cfg.lat   <= din[2+:LAT_W];
        end
    end
endmodule

// File: rtl/flash_rd_burst.sv
module flash_rd_burst
    import flash_rd_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  rd_cfg_t           cfg,
    input  logic              start,
    input  logic              abort,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] cnt,
    output logic              wait_q,
    output logic              valid
);
    logic             active;
    logic [LAT_W-1:0] lat_left;
    logic [ADDR_W-1:0] grp_mask;
    logic [ADDR_W-1:0] cnt_next;

    always_comb begin
        case (cfg.blen)
            BL_FOUR:  grp_mask = ADDR_W'(3);
            BL_EIGHT: grp_mask = ADDR_W'(7);
            default:  grp_mask = '1;
        endcase
        cnt_next = (cnt & ~grp_mask) | ((cnt + ADDR_W'(1)) & grp_mask);
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            active   <= 1'b0;
            lat_left <= '0;
            if (rst) cnt <= '0;
        end else if (start) begin
            active   <= 1'b1;
            cnt      <= start_addr;
            lat_left <= cfg.lat;
        end else if (active) begin
            if (lat_left != '0) lat_left <= lat_left - LAT_W'(1);
            else                cnt      <= cnt_next;
        end
    end

    assign wait_q = active && (lat_left != '0);
    assign valid  = active && (lat_left == '0);
endmodule

// File: rtl/flash_rd_pwr.sv
module flash_rd_pwr (
    input  logic clk,
    input  logic rst,
    input  logic sel_n,
    input  logic rd_en_n,
    input  logic wr_n,
    input  logic addr_vld_n,
    output logic standby,
    output logic psave
);
    always_ff @(posedge clk) begin
        if (rst) begin
            standby <= 1'b0;
            psave   <= 1'b0;
        end else begin
            standby <= sel_n;
            psave   <= !sel_n && rd_en_n && wr_n && addr_vld_n;
        end
    end
endmodule

// File: rtl/flash_burst_rd.sv
module flash_burst_rd
    import flash_rd_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              rd_en_n,
    input  logic              wr_n,
    input  logic              addr_vld_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dq,
    output logic              dq_en,
    output logic              dq_wait,
    output logic              standby,
    output logic              psave
);
    rd_cfg_t           cfg;
    logic              burst_mode;
    logic              wr_stb;
    logic              start;
    logic              valid;
    logic [ADDR_W-1:0] cnt;
    logic [DATA_W-1:0] rdata_a;
    logic [DATA_W-1:0] rdata_b;
    logic [DATA_W-1:0] word;

    assign wr_stb     = !sel_n && !wr_n;
    assign burst_mode = cfg.burst;
    assign start      = !sel_n && !addr_vld_n && wr_n && burst_mode;

    flash_rd_cfg #(.DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .din(din), .cfg(cfg)
    );

    flash_rd_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk(clk), .rst(rst), .cfg(cfg), .start(start),
        .abort(sel_n || wr_stb), .start_addr(addr),
        .cnt(cnt), .wait_q(dq_wait), .valid(valid)
    );

    flash_rd_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .raddr_a(addr), .raddr_b(cnt), .rdata_a(rdata_a), .rdata_b(rdata_b)
    );

    flash_rd_pwr u_pwr (
        .clk(clk), .rst(rst), .sel_n(sel_n), .rd_en_n(rd_en_n),
        .wr_n(wr_n), .addr_vld_n(addr_vld_n),
        .standby(standby), .psave(psave)
    );

    always_comb begin
        if (burst_mode) word = valid ? rdata_b : '0;
        else            word = rdata_a;
    end

    assign dq_en = !sel_n && !rd_en_n;
    assign dq    = dq_en ? word : '0;
endmodule

// File: rtl/flash_burst_rd_chk.sv
module flash_burst_rd_chk (
    input logic clk,
    input logic rst,
    input logic sel_n,
    input logic rd_en_n,
    input logic wr_n,
    input logic dq_wait,
    input logic standby,
    input logic psave,
    input logic burst_mode
);
    AST_DESEL_STANDBY: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> standby); // R9
    AST_DESEL_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> !dq_wait); // R9
    AST_CFG_TO_BURST: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !wr_n) |=> burst_mode); // R4
    AST_RESET_ASYNC: assert property (@(posedge clk)
        rst |=> (!burst_mode && !dq_wait)); // R11
    AST_READ_NO_PSAVE: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !rd_en_n) |=> !psave); // R10
    AST_WAIT_ONLY_BURST: assert property (@(posedge clk) disable iff (rst)
        !burst_mode |-> !dq_wait); // R5
endmodule

bind flash_burst_rd flash_burst_rd_chk u_chk (
    .clk(clk), .rst(rst), .sel_n(sel_n), .rd_en_n(rd_en_n), .wr_n(wr_n),
    .dq_wait(dq_wait), .standby(standby), .psave(psave),
    .burst_mode(burst_mode)
);

// File: tb/flash_burst_rd_tb.sv
module flash_burst_rd_tb;
    localparam int AW = 6;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel_n = 1'b1, rd_en_n = 1'b1, wr_n = 1'b1, addr_vld_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dq;
    logic          dq_en, dq_wait, standby, psave;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    flash_burst_rd #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .rd_en_n(rd_en_n), .wr_n(wr_n),
        .addr_vld_n(addr_vld_n), .addr(addr), .din(din), .dq(dq),
        .dq_en(dq_en), .dq_wait(dq_wait), .standby(standby), .psave(psave)
    );

    function automatic logic [DW-1:0] exp_word(input int a);
        logic [7:0] b = 8'(a);
        return {b ^ 8'h5A, ~b};
    endfunction

    function automatic int exp_addr(input int a, input int n, input int code);
        int m = (code == 0) ? 3 : (code == 1) ? 7 : (1 << AW) - 1;
        return (a & ~m) | ((a + n) & m);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_cfg(input int code, input int lat);
        sel_n = 0; wr_n = 0; addr_vld_n = 1;
        din = DW'((lat << 2) | code);
        addr = AW'($urandom);
        tick();
        wr_n = 1;
    endtask

    task automatic run_burst(input int code, input int lat, input int a, input int nw);
        string tag = (code < 2) ? "R7" : "R8";
        write_cfg(code, lat);
        rd_en_n = 0; addr = AW'(a); #1;
        chk("R4 no data before start", dq, 0);
        chk("R4 no wait before start", dq_wait, 0);
        addr_vld_n = 0;
        tick();
        for (int j = 0; j < lat + nw; j++) begin
            addr_vld_n = 1;
            addr = AW'($urandom);
            chk("R5 wait", dq_wait, (j < lat) ? 1 : 0);
            if (j < lat) chk("R5 zero data", dq, 0);
            else chk({tag, " R6 burst word"}, dq, exp_word(exp_addr(a, j - lat, code)));
            tick();
        end
    endtask

    initial begin
        void'($urandom(32'h5EED));
        tick(); tick();
        chk("R1 wait", dq_wait, 0);
        chk("R1 standby", standby, 0);
        chk("R1 psave", psave, 0);
        chk("R3 enable off", dq_en, 0);
        rst = 0;
        sel_n = 0; rd_en_n = 0;
        for (int i = 0; i < 16; i++) begin
            int a = int'($urandom % (1 << AW));
            addr = AW'(a); #1;
            chk("R2 async read", dq, exp_word(a));
            chk("R3 enable on", dq_en, 1);
            tick();
        end
        rd_en_n = 1; addr = AW'(9); #1;
        chk("R3 oe off data", dq, 0);
        chk("R3 oe off enable", dq_en, 0);

        run_burst(0, 0, 3, 6);
        run_burst(1, 2, 13, 10);
        run_burst(2, 1, 62, 4);
        run_burst(3, 3, 20, 3);
        for (int k = 0; k < 8; k++)
            run_burst(int'($urandom % 4), int'($urandom % 8), int'($urandom % (1 << AW)), 9);

        run_burst(2, 1, 5, 2);
        sel_n = 1; tick();
        chk("R9 standby", standby, 1);
        chk("R9 wait off", dq_wait, 0);
        chk("R9 psave off", psave, 0);
        chk("R9 driver off", dq_en, 0);
        sel_n = 0; rd_en_n = 0; tick();
        chk("R9 no restart", dq, 0);
        chk("R9 standby left", standby, 0);

        rd_en_n = 1; tick();
        chk("R10 psave set", psave, 1);
        chk("R10 not standby", standby, 0);
        rd_en_n = 0; tick();
        chk("R10 psave cleared", psave, 0);

        run_burst(0, 6, 8, 0);
        tick();
        rst = 1; tick(); rst = 0;
        chk("R11 wait cleared", dq_wait, 0);
        addr = AW'(41); #1;
        chk("R11 async again", dq, exp_word(41));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule